// File: doc/BRIEF.md
# Coprocessor Slot Tracker

This block keeps track of coprocessor instructions that run side by side over several cycles. It owns a fixed pool of control slots. Each slot pairs an instruction number with a count of cycles elapsed since that instruction started. A slot reading (0,0) is free. Any other value marks the slot as active.

The host issues at most one instruction per cycle, as a strobe together with an instruction number. The tracker places it in a free slot. The per-instruction behaviour logic, which lies outside this block, reads the slot states. For each active slot it then requests, every cycle, either one more step or release. It also states which functional resources the slot uses that cycle. The tracker raises two registered error flags:
- one when an issue finds every slot active;
- one when two active slots claim a shared resource in the same cycle.

Top module: `coproc_slot_tracker`

## Requirements
- R1: After reset every slot reads instruction number 0 and count 0, and both error flags are low.
- R2: An issue with a non-zero instruction number claims the lowest-indexed free slot. On the next cycle that slot reads (issued number, 1), and no other slot is altered by the claim.
- R3: An active slot with its step request set, and its release request clear, reads its count plus one on the next cycle. Its instruction number is unchanged. The count holds once it reaches its all-ones maximum.
- R4: An active slot with its release request set reads (0,0) on the next cycle. Release takes priority over a step request on the same slot.
- R5: A slot released in a cycle cannot be claimed by an issue in that same cycle. An issue in the following cycle can claim it.
- R6: An issue with a non-zero number while all slots are active sets `issue_full_err` high for exactly the next cycle. No slot is claimed.
- R7: `res_clash_err` is high on the cycle after a cycle in which two active slots both set the same bit of their resource request. Bit k of a slot's request field names resource k. Active slots with disjoint requests leave the flag low.
- R8: Step, release and resource requests on a free slot have no effect. The slot stays (0,0), and its resources never count toward a clash.
- R9: An issue with instruction number 0 is ignored. No slot is claimed and no error is raised.
- R10: An active slot with neither request set keeps its number and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_vld | input | 1 | Issue strobe from the host |
| issue_num | input | NUM_W | Decoded instruction number of the issue |
| step_req | input | NSLOT | Per-slot request to advance the count |
| rel_req | input | NSLOT | Per-slot request to release the slot |
| res_req | input | NSLOT*NRES | Per-slot resource bit set; slot i uses bits [i*NRES +: NRES] |
| slot_num | output | NSLOT*NUM_W | Instruction number of each slot, slot i at [i*NUM_W +: NUM_W] |
| slot_cnt | output | NSLOT*CNT_W | Cycle count of each slot, slot i at [i*CNT_W +: CNT_W] |
| slot_busy | output | NSLOT | Slot active flags |
| issue_full_err | output | 1 | Issue arrived with no free slot (registered) |
| res_clash_err | output | 1 | Two active slots shared a resource (registered) |

## Verification
Release and claim can fall in the same cycle: one slot is told to release while an issue arrives. The bench provokes this with the pool full and with the pool partly free, in both directed steps and a long pseudo-random sweep. It judges the outcome against a slot model that follows the requirements. With a full pool the issue must be refused and flagged while the released slot turns free. The freed slot must be taken only by an issue in the following cycle. Step requests against saturated counts and resource overlaps involving free slots are hit the same way.

// File: rtl/coproc_slot_tracker.sv
module coproc_slot_tracker #(
  parameter int NSLOT = 4,
  parameter int NUM_W = 4,
  parameter int CNT_W = 8,
  parameter int NRES  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   issue_vld,
  input  logic [NUM_W-1:0]       issue_num,
  input  logic [NSLOT-1:0]       step_req,
  input  logic [NSLOT-1:0]       rel_req,
  input  logic [NSLOT*NRES-1:0]  res_req,
  output logic [NSLOT*NUM_W-1:0] slot_num,
  output logic [NSLOT*CNT_W-1:0] slot_cnt,
  output logic [NSLOT-1:0]       slot_busy,
  output logic                   issue_full_err,
  output logic                   res_clash_err
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [NSLOT-1:0] ONE_V   = NSLOT'(1);

  logic [NUM_W-1:0] num_q [NSLOT];
  logic [CNT_W-1:0] cnt_q [NSLOT];
  logic [NSLOT-1:0] busy, free_v, grant;
  logic             issue_go, clash_d;

  assign issue_go  = issue_vld && (issue_num != '0);
  assign free_v    = ~busy;
  assign grant     = issue_go ? (free_v & (~free_v + ONE_V)) : '0;
  assign slot_busy = busy;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign busy[i] = (num_q[i] != '0) || (cnt_q[i] != '0);
    assign slot_num[i*NUM_W +: NUM_W] = num_q[i];
    assign slot_cnt[i*CNT_W +: CNT_W] = cnt_q[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        num_q[i] <= '0;
        cnt_q[i] <= '0;
      end else if (grant[i]) begin
        num_q[i] <= issue_num;
        cnt_q[i] <= CNT_ONE;
      end else if (busy[i]) begin
        if (rel_req[i]) begin
          num_q[i] <= '0;
          cnt_q[i] <= '0;
        end else if (step_req[i] && cnt_q[i] != CNT_MAX) begin
          cnt_q[i] <= cnt_q[i] + CNT_ONE;
        end
      end
    end

    localparam logic [NSLOT-1:0] BELOW = (ONE_V << i) - ONE_V;

    AST_CLAIM_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      issue_go && free_v[i] && ((free_v & BELOW) == '0)
      |=> num_q[i] == $past(issue_num) && cnt_q[i] == CNT_ONE); // R2
    AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      busy[i] && rel_req[i] |=> !busy[i]); // R4
    AST_STEP_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      busy[i] && step_req[i] && !rel_req[i] && cnt_q[i] != CNT_MAX
      |=> cnt_q[i] == $past(cnt_q[i]) + CNT_ONE && $stable(num_q[i])); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      busy[i] && !step_req[i] && !rel_req[i]
      |=> $stable(cnt_q[i]) && $stable(num_q[i])); // R10
    AST_FREE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      !busy[i] && !issue_go |=> !busy[i]); // R8
  end

  always_comb begin
    logic [NRES-1:0] seen;
    seen    = '0;
    clash_d = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin
      if (busy[i]) begin
        if ((seen & res_req[i*NRES +: NRES]) != '0) clash_d = 1'b1;
        seen = seen | res_req[i*NRES +: NRES];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issue_full_err <= 1'b0;
      res_clash_err  <= 1'b0;
    end else begin
      issue_full_err <= issue_go && (&busy);
      res_clash_err  <= clash_d;
    end
  end

  AST_FULL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    issue_go && (&busy) |=> issue_full_err); // R6
  AST_NO_FALSE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_go |=> !issue_full_err); // R9

endmodule

// File: tb/sim_coproc_slot_tracker.sv
module sim_coproc_slot_tracker;
  localparam int NS = 4, NW = 3, CW = 3, NR = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic issue_vld = 1'b0;
  logic [NW-1:0] issue_num = '0;
  logic [NS-1:0] step_req = '0, rel_req = '0;
  logic [NS*NR-1:0] res_req = '0;
  logic [NS*NW-1:0] slot_num;
  logic [NS*CW-1:0] slot_cnt;
  logic [NS-1:0] slot_busy;
  logic issue_full_err, res_clash_err;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_num [NS];
  int m_cnt [NS];
  int m_ferr = 0, m_cerr = 0;

  always #4 clk = ~clk;

  coproc_slot_tracker #(.NSLOT(NS), .NUM_W(NW), .CNT_W(CW), .NRES(NR)) u0 (
    .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .issue_num(issue_num),
    .step_req(step_req), .rel_req(rel_req), .res_req(res_req),
    .slot_num(slot_num), .slot_cnt(slot_cnt), .slot_busy(slot_busy),
    .issue_full_err(issue_full_err), .res_clash_err(res_clash_err));

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    for (int i = 0; i < NS; i++) begin
      chk(tag, int'(slot_num[i*NW +: NW]), m_num[i], $sformatf("slot%0d num", i));
      chk(tag, int'(slot_cnt[i*CW +: CW]), m_cnt[i], $sformatf("slot%0d cnt", i));
      chk(tag, int'(slot_busy[i]), int'(m_num[i] != 0 || m_cnt[i] != 0), $sformatf("slot%0d busy", i));
    end
    chk(tag, int'(issue_full_err), m_ferr, "issue_full_err");
    chk(tag, int'(res_clash_err), m_cerr, "res_clash_err");
  endtask

  // drive one cycle at a falling edge, predict, compare at the next falling edge
  task automatic cyc(string tag, bit iv, int inum, int st, int rl, int rs);
    int nn [NS];
    int nc [NS];
    int seen, claimed;
    bit go, full;
    issue_vld = iv; issue_num = NW'(inum);
    step_req = NS'(st); rel_req = NS'(rl); res_req = (NS*NR)'(rs);
    go = iv && inum != 0;
    full = 1; claimed = -1; seen = 0; m_cerr = 0;
    for (int i = 0; i < NS; i++) begin
      nn[i] = m_num[i]; nc[i] = m_cnt[i];
      if (m_num[i] == 0 && m_cnt[i] == 0) begin
        full = 0;
        if (claimed < 0) claimed = i;
      end else begin
        int r = (rs >> (i*NR)) & ((1 << NR) - 1);
        if ((seen & r) != 0) m_cerr = 1;
        seen = seen | r;
        if ((rl >> i) & 1) begin nn[i] = 0; nc[i] = 0; end
        else if (((st >> i) & 1) && m_cnt[i] < CMAX) nc[i] = m_cnt[i] + 1;
      end
    end
    if (go && claimed >= 0) begin nn[claimed] = inum; nc[claimed] = 1; end
    m_ferr = int'(go && full);
    @(negedge clk);
    for (int i = 0; i < NS; i++) begin m_num[i] = nn[i]; m_cnt[i] = nc[i]; end
    compare(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < NS; i++) begin m_num[i] = 0; m_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    cyc("R1", 0, 0, 0, 0, 0);
    cyc("R2", 1, 5, 0, 0, 0);            // slot0 = (5,1)
    cyc("R2", 1, 3, 'b0001, 0, 0);       // slot1 = (3,1), slot0 steps
    for (int k = 0; k < 7; k++) cyc("R3", 0, 0, 'b0001, 0, 0);  // saturates at 7
    cyc("R10", 0, 0, 0, 0, 0);
    cyc("R4", 0, 0, 'b0001, 'b0001, 0);  // release beats step
    cyc("R9", 1, 0, 0, 0, 0);            // number 0 ignored
    cyc("R8", 0, 0, 'b0001, 'b0001, 'b111); // requests on free slot0
    cyc("R2", 1, 1, 0, 0, 0);            // lowest free is slot0
    cyc("R2", 1, 2, 0, 0, 0);            // slot2
    cyc("R2", 1, 4, 0, 0, 0);            // slot3, pool full
    cyc("R5", 1, 6, 0, 'b0010, 0);       // full + release slot1 same cycle
    cyc("R6", 0, 0, 0, 0, 0);
    cyc("R5", 1, 6, 0, 0, 0);            // slot1 now claimable
    cyc("R6", 1, 7, 0, 0, 0);            // full again
    cyc("R7", 0, 0, 0, 0, 'b000_000_001_001); // slot0/slot1 share bit0
    cyc("R7", 0, 0, 0, 0, 'b100_000_010_001); // disjoint
    cyc("R7", 0, 0, 0, 'b1000, 'b001_000_000_000);
    cyc("R8", 0, 0, 0, 0, 'b001_000_000_001); // slot3 free: no clash
    lf = 16'hACE1;
    for (int k = 0; k < 4000; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc("R3 sweep", lf[0], int'(lf[3:1]), int'(lf[7:4]),
          int'(lf[11:8] & lf[15:12] & {lf[2], lf[5], lf[9], lf[13]}),
          int'({lf[11:0]} & {lf[3:0], lf[15:8]}));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule